// File: doc/BRIEF.md
# Full-Search Block-Matching SAD Array

This block runs an exhaustive block-matching motion search for one small current block against a fixed window of reference pixels. A grid of processing elements, one per current-block pixel, forms one absolute difference each per cycle. The differences pass through a registered adder tree, so one candidate displacement is scored per cycle. A running-minimum stage keeps the best displacement and reports it together with its SAD and a one-cycle completion strobe.

Reference pixels are written once into small memories spread over the elements. A pixel's row and column, each reduced modulo the block size, pick the element that stores it, and it never moves after that. During a search the current-block pixels rotate through the grid instead. Each element holds two current-block registers: a working copy that rotates, and a staging copy that is loaded through a neighbour-to-neighbour shift chain. The staging copy can be refilled while a search runs. A new search can then begin in the cycle right after the previous search's last candidate, with no idle cycle between blocks.

With default parameters the block is 4x4 pixels, the displacement range is -4..+3 on each axis (64 candidates), and the reference window is 11x11 pixels.

Top module: `sad_search_array`

## Requirements
- R1: After reset, `done` is low, `mv_x` and `mv_y` read 0 and `best_sad` reads 0.
- R2: Each cycle with `cur_valid` high shifts `cur_pix` into the staging chain. The last 16 pixels shifted in form the next current block, in raster order: the first of the 16 is the top-left pixel and row 0 comes first.
- R3: Each cycle with `sa_valid` high, when no search is running, stores `sa_pix` at the next window position. Positions run in raster order over the 11x11 window and wrap to the top-left after 121 pixels. Window pixel (row wr, column wc) is compared with current pixel (r, c) at displacement dx = wc - c - 4, dy = wr - r - 4.
- R4: The SAD of a candidate is the sum of |current - window| over the 16 pixel pairs, reported unsigned on 12 bits (at most 4080).
- R5: A search scores all 64 displacements and reports the smallest SAD. It reports the matching displacement on `mv_x`/`mv_y` as 3-bit two's complement values in -4..+3.
- R6: Candidates are scanned with dy as the outer loop and dx as the inner loop, both ascending. On equal SADs the first candidate in that order is reported.
- R7: `done` is high for exactly one cycle. That cycle follows the 66th rising edge after the edge that accepted `start`.
- R8: `start` is accepted when no search is running, or in the cycle that holds the last candidate (back-to-back, no gap). At any other time it is ignored.
- R9: While a search is running (64 cycles from the accepting edge), `sa_valid` is ignored. The pixel is not stored and the write position does not advance.
- R10: Loading the staging chain during a search does not change that search's result. The next accepted `start` uses the newly loaded block.
- R11: `mv_x`, `mv_y` and `best_sad` change only in the cycle that `done` is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_valid | input | 1 | Shift `cur_pix` into the staging chain |
| cur_pix | input | 8 | Current-block pixel |
| sa_valid | input | 1 | Write `sa_pix` into the window memories |
| sa_pix | input | 8 | Search-window pixel |
| start | input | 1 | Begin a search with the staged block |
| done | output | 1 | One-cycle result strobe |
| mv_x | output | 3 | Best horizontal displacement, two's complement |
| mv_y | output | 3 | Best vertical displacement, two's complement |
| best_sad | output | 12 | SAD of the best displacement |

## Verification
The bench builds the block with its defaults: 4x4 block, range 8, 8-bit pixels. At that size one search takes only 64 cycles, so a full scan can be checked against an exhaustive behavioural search many times within the run. The bench checks an exact-copy match, all-equal windows and window patterns that repeat every four pixels (ties), the maximum SAD, and a back-to-back pair of searches that overlaps staging loads, stray reference writes and a stray `start`. The range is twice the block size, so the working registers wrap around the grid more than once per row of candidates. This exercises the row-end diagonal rotation.

// File: rtl/me_pkg.sv
package me_pkg;

   // How the working current-block register of an element moves this cycle
   typedef enum logic [1:0] {
      AR_HOLD = 2'd0,   // keep value
      AR_LOAD = 2'd1,   // take staged pixel (block start)
      AR_ROW  = 2'd2,   // take left neighbour (next dx)
      AR_WRAP = 2'd3    // take upper-left neighbour (next dy, dx restarts)
   } ar_move_e;

   function automatic logic [7:0] abs_diff8(input logic [7:0] a, input logic [7:0] b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/me_pe.sv
module me_pe
   import me_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int DEPTH = 9,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pr_shift,
   input  logic [PIX_W-1:0] pr_in,
   output logic [PIX_W-1:0] pr_q,
   input  ar_move_e         move,
   input  logic [PIX_W-1:0] ar_row_in,
   input  logic [PIX_W-1:0] ar_wrap_in,
   output logic [PIX_W-1:0] ar_q,
   input  logic             sa_we,
   input  logic [AW-1:0]    sa_waddr,
   input  logic [PIX_W-1:0] sa_wdata,
   input  logic [AW-1:0]    sa_raddr,
   output logic [PIX_W-1:0] absdiff
);

   logic [PIX_W-1:0] win_mem [DEPTH];
   logic [PIX_W-1:0] win_px;

   always_ff @(posedge clk) begin
      if (!rst_n)        pr_q <= '0;
      else if (pr_shift) pr_q <= pr_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ar_q <= '0;
      else begin
         unique case (move)
            AR_LOAD: ar_q <= pr_q;
            AR_ROW:  ar_q <= ar_row_in;
            AR_WRAP: ar_q <= ar_wrap_in;
            default: ar_q <= ar_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (sa_we) win_mem[sa_waddr] <= sa_wdata;
   end

   assign win_px  = win_mem[sa_raddr];
   assign absdiff = (ar_q > win_px) ? (ar_q - win_px) : (win_px - ar_q);

   // R10: the working copy takes the staged pixel exactly at block start
   a_r10_stage_copy: assert property (@(posedge clk) disable iff (!rst_n)
      move == AR_LOAD |=> ar_q == $past(pr_q));

endmodule

// File: rtl/me_sad_tree.sv
module me_sad_tree #(
   parameter int PIX_W = 8,
   parameter int N     = 16,
   parameter int SAD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] leaf [N],
   output logic [SAD_W-1:0] sad
);

   localparam int NP = 1 << $clog2(N);

   logic [SAD_W-1:0] node [2*NP-1];

   always_comb begin
      for (int k = 0; k < NP; k++)
         node[NP-1+k] = (k < N) ? SAD_W'(leaf[k]) : '0;
      for (int k = NP-2; k >= 0; k--)
         node[k] = node[2*k+1] + node[2*k+2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sad <= '0;
      else        sad <= node[0];
   end

   // R4: a sum of N pixel differences never exceeds N times the pixel maximum
   a_r4_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(sad) <= N * ((1 << PIX_W) - 1));

endmodule

// File: rtl/me_best_finder.sv
module me_best_finder #(
   parameter int SAD_W   = 12,
   parameter int IDX_W   = 6,
   parameter int RST_IDX = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_v,
   input  logic             in_first,
   input  logic             in_last,
   input  logic [IDX_W-1:0] in_idx,
   input  logic [SAD_W-1:0] in_sad,
   output logic [IDX_W-1:0] out_idx,
   output logic [SAD_W-1:0] out_sad,
   output logic             done
);

   logic [SAD_W-1:0] run_sad;
   logic [IDX_W-1:0] run_idx;
   logic             take;

   assign take = in_first || (in_sad < run_sad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_sad <= '0;
         run_idx <= '0;
         out_sad <= '0;
         out_idx <= IDX_W'(RST_IDX);
         done    <= 1'b0;
      end else begin
         done <= in_v && in_last;
         if (in_v && take) begin
            run_sad <= in_sad;
            run_idx <= in_idx;
         end
         if (in_v && in_last) begin
            out_sad <= take ? in_sad : run_sad;
            out_idx <= take ? in_idx : run_idx;
         end
      end
   end

   // R7: the strobe never lasts two cycles
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: an equal score later in the scan leaves the held candidate alone
   a_r6_keep_earlier: assert property (@(posedge clk) disable iff (!rst_n)
      in_v && !in_first && in_sad == run_sad |=> run_idx == $past(run_idx));

   // R11: published result only moves with the strobe
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(out_sad) || $past(!rst_n));

endmodule

// File: rtl/sad_search_array.sv
module sad_search_array
   import me_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int BLK   = 4,
   parameter int RANGE = 8,
   localparam int OFF_W = $clog2(RANGE),
   localparam int SAD_W = PIX_W + $clog2(BLK*BLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_valid,
   input  logic [PIX_W-1:0] cur_pix,
   input  logic             sa_valid,
   input  logic [PIX_W-1:0] sa_pix,
   input  logic             start,
   output logic             done,
   output logic [OFF_W-1:0] mv_x,
   output logic [OFF_W-1:0] mv_y,
   output logic [SAD_W-1:0] best_sad
);

   localparam int NPE   = BLK * BLK;
   localparam int WIN   = BLK + RANGE - 1;
   localparam int NB    = (WIN + BLK - 1) / BLK;
   localparam int DEPTH = NB * NB;
   localparam int AW    = $clog2(DEPTH);
   localparam int NCAND = RANGE * RANGE;
   localparam int CNT_W = $clog2(NCAND);
   localparam int RC_W  = $clog2(WIN);
   localparam int LB    = $clog2(BLK);
   localparam int HALF  = RANGE / 2;

   generate
      if ((BLK & (BLK - 1)) != 0 || BLK < 2)
         begin : g_bad_blk   $error("BLK must be a power of two of at least 2"); end
      if ((RANGE & (RANGE - 1)) != 0 || (RANGE % BLK) != 0)
         begin : g_bad_range $error("RANGE must be a power of two and a multiple of BLK"); end
      if (PIX_W != 8)
         begin : g_bad_pix   $error("PIX_W must be 8"); end
   endgenerate

   // ---------------- search sequencing ----------------
   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             last_cand, go;
   logic [OFF_W-1:0] ox, oy;
   ar_move_e         move;

   assign last_cand = busy && (cnt == CNT_W'(NCAND - 1));
   assign go        = start && (!busy || last_cand);
   assign ox        = cnt[OFF_W-1:0];
   assign oy        = cnt[CNT_W-1:OFF_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (go) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last_cand) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt + CNT_W'(1);
      end
   end

   always_comb begin
      if (go)                                move = AR_LOAD;
      else if (busy && !last_cand)
         move = (ox == {OFF_W{1'b1}}) ? AR_WRAP : AR_ROW;
      else                                   move = AR_HOLD;
   end

   // ---------------- window write pointer ----------------
   logic [RC_W-1:0] wr_row, wr_col;
   logic            sa_take;
   logic [AW-1:0]   waddr;

   assign sa_take = sa_valid && !busy;
   assign waddr   = AW'(int'(wr_row >> LB) * NB + int'(wr_col >> LB));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_row <= '0;
         wr_col <= '0;
      end else if (sa_take) begin
         if (wr_col == RC_W'(WIN - 1)) begin
            wr_col <= '0;
            wr_row <= (wr_row == RC_W'(WIN - 1)) ? '0 : wr_row + RC_W'(1);
         end else begin
            wr_col <= wr_col + RC_W'(1);
         end
      end
   end

   // ---------------- element grid ----------------
   logic [PIX_W-1:0] pr_q  [NPE];
   logic [PIX_W-1:0] ar_q  [NPE];
   logic [PIX_W-1:0] diff  [NPE];
   logic [AW-1:0]    raddr [NPE];

   genvar gi, gj;
   generate
      for (gi = 0; gi < BLK; gi++) begin : g_row
         for (gj = 0; gj < BLK; gj++) begin : g_col
            localparam int K     = gi * BLK + gj;
            localparam int LEFT  = gi * BLK + (gj + BLK - 1) % BLK;
            localparam int UPLFT = ((gi + BLK - 1) % BLK) * BLK + (gj + BLK - 1) % BLK;

            logic [PIX_W-1:0] chain_in;
            logic             we;

            if (K == NPE - 1) begin : g_head
               assign chain_in = cur_pix;
            end else begin : g_link
               assign chain_in = pr_q[K+1];
            end

            assign we = sa_take && (wr_row[LB-1:0] == LB'(gi)) && (wr_col[LB-1:0] == LB'(gj));

            // Which stored pixel this element's rotated current pixel meets
            always_comb begin
               int r, c;
               r = (gi - int'(oy) % BLK + BLK) % BLK;
               c = (gj - int'(ox) % BLK + BLK) % BLK;
               raddr[K] = AW'(((r + int'(oy)) / BLK) * NB + (c + int'(ox)) / BLK);
            end

            me_pe #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)) i_pe (
               .clk        (clk),
               .rst_n      (rst_n),
               .pr_shift   (cur_valid),
               .pr_in      (chain_in),
               .pr_q       (pr_q[K]),
               .move       (move),
               .ar_row_in  (ar_q[LEFT]),
               .ar_wrap_in (ar_q[UPLFT]),
               .ar_q       (ar_q[K]),
               .sa_we      (we),
               .sa_waddr   (waddr),
               .sa_wdata   (sa_pix),
               .sa_raddr   (raddr[K]),
               .absdiff    (diff[K])
            );
         end
      end
   endgenerate

   // ---------------- difference register stage ----------------
   logic [PIX_W-1:0] diff_q [NPE];
   logic             v1, first1, last1, v2, first2, last2;
   logic [CNT_W-1:0] idx1, idx2;
   logic [SAD_W-1:0] sad2;
   logic [CNT_W-1:0] best_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NPE; k++) diff_q[k] <= '0;
         v1 <= 1'b0; first1 <= 1'b0; last1 <= 1'b0; idx1 <= '0;
         v2 <= 1'b0; first2 <= 1'b0; last2 <= 1'b0; idx2 <= '0;
      end else begin
         for (int k = 0; k < NPE; k++) diff_q[k] <= diff[k];
         v1     <= busy;
         first1 <= busy && (cnt == '0);
         last1  <= last_cand;
         idx1   <= cnt;
         v2     <= v1;
         first2 <= first1;
         last2  <= last1;
         idx2   <= idx1;
      end
   end

   me_sad_tree #(.PIX_W(PIX_W), .N(NPE), .SAD_W(SAD_W)) i_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .leaf  (diff_q),
      .sad   (sad2)
   );

   me_best_finder #(.SAD_W(SAD_W), .IDX_W(CNT_W), .RST_IDX(HALF * RANGE + HALF)) i_find (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (v2),
      .in_first (first2),
      .in_last  (last2),
      .in_idx   (idx2),
      .in_sad   (sad2),
      .out_idx  (best_idx),
      .out_sad  (best_sad),
      .done     (done)
   );

   assign mv_x = best_idx[OFF_W-1:0]     - OFF_W'(HALF);
   assign mv_y = best_idx[CNT_W-1:OFF_W] - OFF_W'(HALF);

   // R9: window writes during a search leave the write position untouched
   a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && sa_valid |=> $stable(wr_row) && $stable(wr_col));

   // R8: a start in the middle of a search does not restart the scan
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !last_cand |=> busy && cnt == $past(cnt) + CNT_W'(1));

   // R8: a start on the last candidate opens a new scan at once
   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      last_cand && start |=> busy && cnt == '0);

endmodule

// File: tb/test_sad_search_array.sv
module test_sad_search_array;

   localparam int BLK = 4, RANGE = 8, WIN = BLK + RANGE - 1, NW = WIN * WIN, NC = BLK * BLK;
   localparam int LAT = 66;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cur_valid = 1'b0, sa_valid = 1'b0, start = 1'b0;
   logic [7:0] cur_pix = '0, sa_pix = '0;
   logic       done;
   logic [2:0] mv_x, mv_y;
   logic [11:0] best_sad;

   sad_search_array i_sad_search_array (
      .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .cur_pix(cur_pix),
      .sa_valid(sa_valid), .sa_pix(sa_pix), .start(start),
      .done(done), .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad));

   always #10 clk = ~clk;   // 50 MHz

   int vectors = 0, fails = 0, cyc = 0;
   bit checking = 1'b0;
   string tag = "R1";
   int win_m [NW];
   int cur_m [NC];
   int q_cyc[$], q_dx[$], q_dy[$], q_sad[$];
   int exp_dx = 0, exp_dy = 0, exp_sad = 0;
   int seed = 12345;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (%s) actual=%0d expected=%0d at cycle %0d", req, tag, act, exp, cyc);
      end
   endtask

   function automatic int rnd8();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 16) & 255;
   endfunction

   // exhaustive search, dy outer, dx inner, strict improvement keeps earliest
   task automatic model(output int bdx, output int bdy, output int bsad);
      bsad = -1; bdx = 0; bdy = 0;
      for (int oy = 0; oy < RANGE; oy++)
         for (int ox = 0; ox < RANGE; ox++) begin
            int s;
            s = 0;
            for (int r = 0; r < BLK; r++)
               for (int c = 0; c < BLK; c++) begin
                  int d;
                  d = cur_m[r*BLK+c] - win_m[(r+oy)*WIN + c+ox];
                  s += (d < 0) ? -d : d;
               end
            if (bsad < 0 || s < bsad) begin
               bsad = s; bdx = ox - RANGE/2; bdy = oy - RANGE/2;
            end
         end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // per-clock comparison against the model timeline
   always @(negedge clk) begin
      if (checking) begin
         bit exp_done;
         exp_done = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
         chk(done == exp_done, "R7", int'(done), int'(exp_done));
         if (exp_done) begin
            exp_dx = q_dx.pop_front(); exp_dy = q_dy.pop_front(); exp_sad = q_sad.pop_front();
            void'(q_cyc.pop_front());
            chk(int'($signed(mv_x)) == exp_dx, "R5", int'($signed(mv_x)), exp_dx);
            chk(int'($signed(mv_y)) == exp_dy, "R5", int'($signed(mv_y)), exp_dy);
            chk(int'(best_sad) == exp_sad, "R4", int'(best_sad), exp_sad);
         end else begin
            chk(int'($signed(mv_x)) == exp_dx && int'($signed(mv_y)) == exp_dy,
                "R11", int'($signed(mv_x)) * 16 + int'($signed(mv_y)), exp_dx * 16 + exp_dy);
            chk(int'(best_sad) == exp_sad, "R11", int'(best_sad), exp_sad);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog expired (%s) actual=%0d expected=0", tag, cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic load_win();   // R3: raster order over the window
      for (int k = 0; k < NW; k++) begin
         sa_pix = 8'(win_m[k]); sa_valid = 1'b1; @(negedge clk);
      end
      sa_valid = 1'b0;
   endtask

   task automatic load_cur();   // R2: raster order, first pixel is top-left
      for (int k = 0; k < NC; k++) begin
         cur_pix = 8'(cur_m[k]); cur_valid = 1'b1; @(negedge clk);
      end
      cur_valid = 1'b0;
   endtask

   task automatic do_start();   // drive so that the next edge accepts it
      int dx, dy, s;
      model(dx, dy, s);
      q_cyc.push_back(cyc + 1 + LAT); q_dx.push_back(dx); q_dy.push_back(dy); q_sad.push_back(s);
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic drain();
      while (q_cyc.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int p;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk(done == 1'b0, "R1", int'(done), 0);
      chk(mv_x == 3'd0 && mv_y == 3'd0, "R1", int'(mv_x) * 8 + int'(mv_y), 0);
      chk(best_sad == 12'd0, "R1", int'(best_sad), 0);
      checking = 1'b1;

      // R2 R3 R5: block copied from the window at dx=+1, dy=-2
      tag = "R2 R3 exact copy";
      for (int k = 0; k < NW; k++) win_m[k] = rnd8();
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) cur_m[r*BLK+c] = win_m[(r+2)*WIN + c+5];
      load_win(); load_cur(); do_start(); drain();
      chk(exp_dx == 1 && exp_dy == -2, "R3", exp_dx * 16 + exp_dy, 1 * 16 - 2);

      // R6: every candidate ties at zero, first in scan order wins
      tag = "R6 all zero";
      for (int k = 0; k < NW; k++) win_m[k] = 0;
      for (int k = 0; k < NC; k++) cur_m[k] = 0;
      load_win(); load_cur(); do_start(); drain();

      // R4: largest possible SAD
      tag = "R4 max sad";
      for (int k = 0; k < NC; k++) cur_m[k] = 255;
      load_cur(); do_start(); drain();
      chk(exp_sad == 4080, "R4", exp_sad, 4080);

      // R6: window repeating every 4 pixels gives many equal minima
      tag = "R6 periodic window";
      for (int k = 0; k < NC; k++) cur_m[k] = rnd8();
      for (int r = 0; r < WIN; r++)
         for (int c = 0; c < WIN; c++) win_m[r*WIN+c] = cur_m[((r+1)%BLK)*BLK + (c+3)%BLK];
      load_win(); load_cur(); do_start(); drain();

      // R8 R9 R10: stray writes and start mid-search, staging reload, back-to-back
      tag = "R8 R9 R10 overlap";
      for (int k = 0; k < NW; k++) win_m[k] = rnd8();
      for (int k = 0; k < NC; k++) cur_m[k] = rnd8();
      load_win(); load_cur();
      p = cyc + 1;
      do_start();
      for (int k = 0; k < 10; k++) begin   // R9: ignored while searching
         sa_pix = 8'(rnd8()); sa_valid = 1'b1; @(negedge clk);
      end
      sa_valid = 1'b0;
      for (int k = 0; k < NC; k++) cur_m[k] = rnd8();
      load_cur();                           // R10: staged during the search
      start = 1'b1; @(negedge clk); start = 1'b0;   // R8: ignored, no result expected
      while (cyc < p + 63) @(negedge clk);
      do_start();                           // R8: accepted on the last candidate
      drain();

      // R9: stored window and write position unchanged, rerun same block
      tag = "R9 rerun";
      do_start(); drain();

      // R3: full reload lands from the top-left again
      tag = "R3 reload";
      for (int k = 0; k < NW; k++) win_m[k] = rnd8();
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) cur_m[r*BLK+c] = win_m[(r+7)*WIN + c];
      load_win(); load_cur(); do_start(); drain();
      chk(exp_dx == -4 && exp_dy == 3, "R3", exp_dx * 16 + exp_dy, -4 * 16 + 3);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule